// File: doc/BRIEF.md
# Dual-Axis Quadrature Position Counter

This block tracks position on two incremental encoder axes, X and Y, and keeps a 12-bit up/down count for each. Each axis has an A and a B phase input. The block decides the direction of motion from the phase relationship and changes the count by one on every valid edge of either phase. A single-cycle transition in which both phases change is ambiguous, so it is dropped. Each axis has its own synchronous clear. Three push-button inputs are sampled and reported with the count.

A host reads the counts over an 8-bit port. A chip select, an axis select and a byte select steer the port. A low-byte read strobe returns the live low byte and stores the upper count bits of that axis. The matching upper-byte read returns those stored bits, so the two halves always belong to the same sample. The count flag shows that an axis has moved since its last completed read. The switch flag shows that a key is pressed. All encoder and key inputs pass through a synchroniser before they are used.

Top module: `quad_pos_counter`

## Requirements
- R1: With the phases written as {A,B}, the forward sequence 00→10→11→01→00 (A leading B) raises the count by one per step, and the reverse sequence lowers it by one per step.
- R2: Every valid edge of either phase changes the count by exactly one, so one full four-state encoder cycle moves it by four.
- R3: Counts wrap modulo 4096: one step down from 0x000 gives 0xFFF, and one step up from 0xFFF gives 0x000.
- R4: A high clr_x (clr_y) on a clock edge sets that axis count to 0x000 on that edge. Clear takes priority over counting, and the other axis is unaffected.
- R5: A sample in which both A and B change together leaves the count unchanged.
- R6: With cs=1 and sel_hi=0, dout carries bits 7:0 of the live count of the axis picked by sel_y (0 = X, 1 = Y).
- R7: With cs=1 and sel_hi=1, dout[3:0] holds count bits 11:8, dout[4] the left key (keys[0]), dout[5] the middle key (keys[1]), dout[6] the right key (keys[2]), and dout[7] is 0. A key reads 1 while its input is high.
- R8: A clock edge with cs=1, rd=1 and sel_hi=0 stores the selected axis's count bits 11:8. Upper-byte reads of that axis return the stored bits, even if the count has moved since.
- R9: While cs=0, dout is 0x00 and dout_oe is 0. While cs=1, dout_oe is 1.
- R10: cnt_flag rises after any axis count step. It clears once an upper-byte read strobe (cs=1, rd=1, sel_hi=1) has been made on every axis that moved. If a step and a clear fall on the same edge, the step wins.
- R11: sw_flag is 1 while at least one key input is high, after the synchroniser delay.
- R12: The counters and the flags reset to zero. An input change reaches the count after three clock edges: two synchroniser stages and one decode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| x_a | input | 1 | X axis phase A |
| x_b | input | 1 | X axis phase B |
| y_a | input | 1 | Y axis phase A |
| y_b | input | 1 | Y axis phase B |
| keys | input | KEY_N | Key inputs: bit 0 left, bit 1 middle, bit 2 right, high = pressed |
| clr_x | input | 1 | Synchronous clear of the X count |
| clr_y | input | 1 | Synchronous clear of the Y count |
| cs | input | 1 | Chip select, active high |
| sel_y | input | 1 | Axis select: 0 = X, 1 = Y |
| sel_hi | input | 1 | Byte select: 0 = low byte, 1 = upper byte |
| rd | input | 1 | Read strobe, one cycle per access |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | Output enable for dout |
| cnt_flag | output | 1 | An axis has moved since its last completed read |
| sw_flag | output | 1 | At least one key is pressed |

## Verification
The bench builds the block with its defaults: CNT_W=12, DATA_W=8, KEY_N=3 and SYNC_STAGES=2. With a 12-bit count, both wrap directions can be reached in a single step from a cleared axis. A carry out of the low byte takes 256 steps, and the split-read test needs one so that stored and live upper bits differ. With two synchroniser stages the input-to-count latency is a fixed three edges, so the bench can settle after each move and compare its own model counts exactly. Random moves, clears and key patterns on both axes are mixed with directed cases for the ambiguous double change, the wraps and the flag handshake.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  localparam int NUM_AXES = 2;
  localparam int AXIS_X   = 0;
  localparam int AXIS_Y   = 1;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2,
    STEP_SKIP = 2'd3
  } step_e;

  // cur/prv are {A,B}; forward when new A differs from old B
  function automatic step_e classify(input logic [1:0] cur, input logic [1:0] prv);
    logic [1:0] diff;
    diff = cur ^ prv;
    if (diff == 2'b00)      return STEP_HOLD;
    else if (diff == 2'b11) return STEP_SKIP;
    else if (cur[1] ^ prv[0]) return STEP_INC;
    else                    return STEP_DEC;
  endfunction

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/qpc_axis.sv
module qpc_axis
  import qpc_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ab,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             moved
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0]       prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  step_e            step;

  always_comb begin
    step   = classify(ab, prev_q);
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (step == STEP_INC) begin
      cnt_d  = cnt_q + ONE;
      cnt_en = 1'b1;
    end else if (step == STEP_DEC) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
    end else begin
      prev_q <= ab;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt   = cnt_q;
  assign moved = !clr && ((step == STEP_INC) || (step == STEP_DEC));

endmodule

// File: rtl/qpc_readout.sv
module qpc_readout
  import qpc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8,
  parameter int KEY_N  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_AXES-1:0][CNT_W-1:0]    cnt,
  input  logic [NUM_AXES-1:0]               moved,
  input  logic [KEY_N-1:0]                  keys,
  input  logic                              cs,
  input  logic                              sel_y,
  input  logic                              sel_hi,
  input  logic                              rd,
  output logic [DATA_W-1:0]                 dout,
  output logic                              dout_oe,
  output logic                              cnt_flag
);

  localparam int HI_W  = CNT_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W - KEY_N;

  logic [NUM_AXES-1:0][HI_W-1:0] hold_q;
  logic [NUM_AXES-1:0][HI_W-1:0] hold_d;
  logic [NUM_AXES-1:0]           hold_en;
  logic [NUM_AXES-1:0]           pend_q;
  logic [NUM_AXES-1:0]           pend_d;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    logic hit;
    logic lo_strobe;
    logic hi_strobe;

    assign hit       = cs && rd && (sel_y == a[0]);
    assign lo_strobe = hit && !sel_hi;
    assign hi_strobe = hit && sel_hi;

    always_comb begin
      hold_en[a] = lo_strobe;
      hold_d[a]  = cnt[a][CNT_W-1:DATA_W];
      if (moved[a])       pend_d[a] = 1'b1;
      else if (hi_strobe) pend_d[a] = 1'b0;
      else                pend_d[a] = pend_q[a];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q[a] <= '0;
      end else if (hold_en[a]) begin
        hold_q[a] <= hold_d[a];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[a] <= 1'b0;
      end else begin
        pend_q[a] <= pend_d[a];
      end
    end
  end

  always_comb begin
    if (!cs) begin
      dout = '0;
    end else if (!sel_hi) begin
      dout = cnt[sel_y][DATA_W-1:0];
    end else begin
      dout = {{PAD_W{1'b0}}, keys, hold_q[sel_y]};
    end
  end

  assign dout_oe  = cs;
  assign cnt_flag = |pend_q;

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int DATA_W      = 8,
  parameter int KEY_N       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_a,
  input  logic              x_b,
  input  logic              y_a,
  input  logic              y_b,
  input  logic [KEY_N-1:0]  keys,
  input  logic              clr_x,
  input  logic              clr_y,
  input  logic              cs,
  input  logic              sel_y,
  input  logic              sel_hi,
  input  logic              rd,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              cnt_flag,
  output logic              sw_flag
);

  localparam int PH_W   = 2 * NUM_AXES;
  localparam int SYNC_W = PH_W + KEY_N;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_pipe_q[1];

  logic [SYNC_W-1:0] sync_d;
  logic [SYNC_W-1:0] sync_q;

  assign sync_d = {keys, y_a, y_b, x_a, x_b};

  qpc_sync #(
    .W      (SYNC_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_ni),
    .d     (sync_d),
    .q     (sync_q)
  );

  logic [NUM_AXES-1:0][1:0]       ab_s;
  logic [NUM_AXES-1:0]            clr_vec;
  logic [NUM_AXES-1:0][CNT_W-1:0] cnt_w;
  logic [NUM_AXES-1:0]            moved_w;
  logic [KEY_N-1:0]               keys_s;

  assign clr_vec = {clr_y, clr_x};
  assign keys_s  = sync_q[PH_W +: KEY_N];

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axes
    assign ab_s[a] = sync_q[2*a +: 2];

    qpc_axis #(
      .CNT_W (CNT_W)
    ) u_axis (
      .clk   (clk),
      .rst_n (rst_ni),
      .ab    (ab_s[a]),
      .clr   (clr_vec[a]),
      .cnt   (cnt_w[a]),
      .moved (moved_w[a])
    );
  end

  logic [CNT_W-1:0] cnt_x_w;
  logic [CNT_W-1:0] cnt_y_w;
  assign cnt_x_w = cnt_w[AXIS_X];
  assign cnt_y_w = cnt_w[AXIS_Y];

  qpc_readout #(
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W),
    .KEY_N  (KEY_N)
  ) u_readout (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cnt      (cnt_w),
    .moved    (moved_w),
    .keys     (keys_s),
    .cs       (cs),
    .sel_y    (sel_y),
    .sel_hi   (sel_hi),
    .rd       (rd),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .cnt_flag (cnt_flag)
  );

  assign sw_flag = |keys_s;

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              sel_hi,
  input logic              dout_oe,
  input logic [DATA_W-1:0] dout,
  input logic              clr_x,
  input logic              clr_y,
  input logic [CNT_W-1:0]  cnt_x,
  input logic [CNT_W-1:0]  cnt_y,
  input logic [1:0]        ab_x,
  input logic [1:0]        ab_y,
  input logic              moved_x,
  input logic              moved_y,
  input logic              cnt_flag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  a_r9_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (dout == '0) && !dout_oe);

  a_r9_oe_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> dout_oe);

  a_r7_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cs && sel_hi |-> !dout[DATA_W-1]);

  a_r4_clear_x: assert property (@(posedge clk) disable iff (!rst_n)
    clr_x |=> (cnt_x == '0));

  a_r4_clear_y: assert property (@(posedge clk) disable iff (!rst_n)
    clr_y |=> (cnt_y == '0));

  a_r2_single_step_x: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_x) |-> (cnt_x == $past(cnt_x)) || (cnt_x == $past(cnt_x) + ONE)
                      || (cnt_x == $past(cnt_x) - ONE));

  a_r2_single_step_y: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_y) |-> (cnt_y == $past(cnt_y)) || (cnt_y == $past(cnt_y) + ONE)
                      || (cnt_y == $past(cnt_y) - ONE));

  a_r5_double_change_x: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_x && ((ab_x ^ $past(ab_x)) == 2'b11) |=> $stable(cnt_x));

  a_r5_double_change_y: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_y && ((ab_y ^ $past(ab_y)) == 2'b11) |=> $stable(cnt_y));

  a_r10_flag_x: assert property (@(posedge clk) disable iff (!rst_n)
    moved_x |=> cnt_flag);

  a_r10_flag_y: assert property (@(posedge clk) disable iff (!rst_n)
    moved_y |=> cnt_flag);

endmodule

bind quad_pos_counter qpc_checker #(
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_qpc_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .cs       (cs),
  .sel_hi   (sel_hi),
  .dout_oe  (dout_oe),
  .dout     (dout),
  .clr_x    (clr_x),
  .clr_y    (clr_y),
  .cnt_x    (cnt_x_w),
  .cnt_y    (cnt_y_w),
  .ab_x     (ab_s[0]),
  .ab_y     (ab_s[1]),
  .moved_x  (moved_w[0]),
  .moved_y  (moved_w[1]),
  .cnt_flag (cnt_flag)
);

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 12;
  localparam int DATA_W     = 8;
  localparam int KEY_N      = 3;

  logic              clk;
  logic              rst_n;
  logic              x_a, x_b, y_a, y_b;
  logic [KEY_N-1:0]  keys;
  logic              clr_x, clr_y;
  logic              cs, sel_y, sel_hi, rd;
  logic [DATA_W-1:0] dout;
  logic              dout_oe, cnt_flag, sw_flag;

  quad_pos_counter u_quad_pos_counter (
    .clk(clk), .rst_n(rst_n), .x_a(x_a), .x_b(x_b), .y_a(y_a), .y_b(y_b),
    .keys(keys), .clr_x(clr_x), .clr_y(clr_y), .cs(cs), .sel_y(sel_y),
    .sel_hi(sel_hi), .rd(rd), .dout(dout), .dout_oe(dout_oe),
    .cnt_flag(cnt_flag), .sw_flag(sw_flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  logic [1:0]       ph  [2];
  logic [CNT_W-1:0] exp_cnt [2];
  logic [CNT_W-1:0] cap_cnt [2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // forward order of {A,B}: 00 -> 10 -> 11 -> 01 -> 00
  function automatic logic [1:0] next_ph(input logic [1:0] cur, input bit up);
    case (cur)
      2'b00: return up ? 2'b10 : 2'b01;
      2'b10: return up ? 2'b11 : 2'b00;
      2'b11: return up ? 2'b01 : 2'b10;
      default: return up ? 2'b00 : 2'b11;
    endcase
  endfunction

  function automatic logic [7:0] hi_byte(input logic [CNT_W-1:0] c, input logic [KEY_N-1:0] k);
    return {1'b0, k, c[11:8]};
  endfunction

  task automatic drive_ph(input int ax);
    if (ax == 0) {x_a, x_b} = ph[0];
    else         {y_a, y_b} = ph[1];
  endtask

  task automatic step_axis(input int ax, input bit up);
    @(negedge clk);
    ph[ax] = next_ph(ph[ax], up);
    drive_ph(ax);
    exp_cnt[ax] = up ? exp_cnt[ax] + 12'd1 : exp_cnt[ax] - 12'd1;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_axis(input int ax);
    @(negedge clk);
    if (ax == 0) clr_x = 1'b1; else clr_y = 1'b1;
    @(negedge clk);
    clr_x = 1'b0;
    clr_y = 1'b0;
    exp_cnt[ax] = '0;
  endtask

  task automatic read_low(input int ax, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; sel_y = ax[0]; sel_hi = 1'b0; rd = 1'b1;
    #1 v = dout;
    cap_cnt[ax] = exp_cnt[ax];
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic read_high(input int ax, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; sel_y = ax[0]; sel_hi = 1'b1; rd = 1'b1;
    #1 v = dout;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic read_check(input int ax, input string tag);
    logic [7:0] lo, hi;
    read_low(ax, lo);
    read_high(ax, hi);
    chk({tag, " low byte"}, lo, exp_cnt[ax][7:0]);
    chk({tag, " upper byte"}, hi, hi_byte(exp_cnt[ax], keys));
  endtask

  initial begin
    logic [7:0] v;
    rst_n = 1'b0;
    {x_a, x_b, y_a, y_b} = '0;
    keys = '0; clr_x = 0; clr_y = 0; cs = 0; sel_y = 0; sel_hi = 0; rd = 0;
    ph[0] = 2'b00; ph[1] = 2'b00;
    exp_cnt[0] = '0; exp_cnt[1] = '0;
    cap_cnt[0] = '0; cap_cnt[1] = '0;
    void'($urandom(32'd20240613));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R12 / R9 reset state
    chk("R12 reset cnt_flag", cnt_flag, 0);
    chk("R12 reset sw_flag", sw_flag, 0);
    chk("R9 idle dout", dout, 0);
    chk("R9 idle oe", dout_oe, 0);
    read_check(0, "R12 reset X");

    // R12 latency: three edges from input change to count
    @(negedge clk);
    ph[0] = next_ph(ph[0], 1); drive_ph(0);
    cs = 1'b1; sel_y = 1'b0; sel_hi = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 count before third edge", dout, 8'h00);
    @(negedge clk);
    chk("R12 count after third edge", dout, 8'h01);
    chk("R9 oe when selected", dout_oe, 1);
    cs = 1'b0;
    exp_cnt[0] = 12'd1;

    // R1 forward on X, R6 low byte
    repeat (4) step_axis(0, 1);
    settle();
    read_check(0, "R1 forward X");

    // R1 reverse on Y and R3 wrap below zero
    repeat (3) step_axis(1, 0);
    settle();
    read_check(1, "R3 wrap down Y");
    chk("R3 Y value", exp_cnt[1], 12'hFFD);

    // R2 one full cycle moves four counts
    clear_axis(0);
    repeat (4) step_axis(0, 1);
    settle();
    read_check(0, "R2 full cycle");

    // R5 both phases change together
    @(negedge clk);
    ph[0] = ph[0] ^ 2'b11; drive_ph(0);
    settle();
    read_check(0, "R5 double change");

    // R4 clear X leaves Y alone
    clear_axis(0);
    settle();
    read_check(0, "R4 clear X");
    read_check(1, "R4 Y untouched");

    // R3 wrap up
    step_axis(0, 0);
    settle();
    read_check(0, "R3 down to FFF");
    step_axis(0, 1);
    settle();
    read_check(0, "R3 up to 000");

    // R7 / R11 keys
    @(negedge clk); keys = 3'b101;
    settle();
    chk("R11 sw_flag pressed", sw_flag, 1);
    read_check(1, "R7 keys right+left");
    @(negedge clk); keys = 3'b010;
    settle();
    read_check(1, "R7 key middle");
    @(negedge clk); keys = 3'b000;
    settle();
    chk("R11 sw_flag released", sw_flag, 0);

    // R8 split read across a low-byte carry
    clear_axis(0);
    repeat (254) step_axis(0, 1);
    settle();
    read_low(0, v);
    chk("R8 low before carry", v, 8'hFE);
    repeat (3) step_axis(0, 1);
    settle();
    read_high(0, v);
    chk("R8 upper from capture", v, hi_byte(cap_cnt[0], keys));
    read_check(0, "R8 fresh read");

    // R10 flag handshake
    read_check(1, "R10 Y read");
    chk("R10 flag clear", cnt_flag, 0);
    step_axis(1, 1);
    settle();
    chk("R10 flag set", cnt_flag, 1);
    read_low(1, v);
    chk("R10 flag held after low read", cnt_flag, 1);
    read_high(1, v);
    chk("R10 flag clear after upper read", cnt_flag, 0);

    // R9 deselected port
    @(negedge clk); cs = 1'b0; sel_hi = 1'b1; sel_y = 1'b1;
    #1 chk("R9 deselected dout", dout, 0);
    chk("R9 deselected oe", dout_oe, 0);

    // random mix, R1 R2 R3 R4 R6 R7
    for (int it = 0; it < 200; it++) begin
      int ax;
      int n;
      bit up;
      ax = $urandom_range(0, 1);
      up = $urandom_range(0, 1);
      n  = $urandom_range(1, 24);
      if ($urandom_range(0, 15) == 0) clear_axis(ax);
      for (int s = 0; s < n; s++) step_axis(ax, up);
      @(negedge clk); keys = KEY_N'($urandom_range(0, 7));
      settle();
      read_check(ax, "R1 random");
    end

    finish_run();
  end

endmodule